// File: doc/BRIEF.md
# USB Receive Qword Ring Packer

The block takes the bytes of OUT packets delivered by a USB device core and stores them in a circular receive area in system memory. Four OUT endpoints feed this single path. The block writes 64-bit words. Each stored packet takes one 8-byte header slot followed by its payload. Payload bytes fill each word starting from the low lane. A partially filled last word has its unused high bytes written as zero.

The byte count is known only at end-of-packet, so the block writes the header last. It goes into the slot reserved at the start of the packet, and a single-cycle interrupt follows once memory accepts it.

Firmware sets the ring base and length while the channel is disabled. It also supplies its current read offset. When a new packet starts, the block checks the free space in the ring. If the space cannot hold a worst-case packet with a safety gap, the whole packet is discarded and a sticky overflow flag is raised.

Top module: `usbrx_qword_packer`

## Requirements
- R1: While `enable` is low, or after reset, no memory write is requested, no byte is accepted, the interrupt is low, the overflow flag is clear, and the ring write offset returns to 0.
- R2: Payload bytes are packed in arrival order. Byte i of the payload goes to bits 8*(i mod 8)+7 : 8*(i mod 8) of payload qword i/8. Payload qword k is written at byte address base + ((H + 8 + 8k) mod len), where H is the packet's header offset.
- R3: The header qword holds the stored payload byte count in bits 6:0, the endpoint number in bits 9:8 and the setup flag in bit 10. Every other bit is zero.
- R4: When the payload length is not a multiple of 8, the unused high bytes of the final payload qword are written as zero.
- R5: An accepted packet produces exactly ceil(n/8) payload writes followed by one header write at offset H. One single-cycle `irq_pkt_done` pulse follows the cycle in which memory accepts the header.
- R6: Offsets wrap modulo the ring length. The next packet's header offset is (H + 8 + 8*ceil(n/8)) mod len.
- R7: At a start-of-packet, the packet is accepted only if the free space is at least 80 bytes. Free space is len minus ((wr - rd) mod len). A packet that is not accepted still has all of its bytes consumed, but it produces no write and no interrupt, and it sets `ovf_flag`. The flag stays set until `enable` goes low.
- R8: A beat with `in_sop`, `in_eop` and `in_zlp` all set is a zero-length packet. It produces only its header, with count 0, and advances the offset by 8.
- R9: Payload bytes beyond the 64th in a packet are consumed but neither stored nor counted, so the count never exceeds 64.
- R10: Once `mem_wr_valid` is high, it stays high with stable address and data until `mem_wr_ready` is seen.
- R11: A byte offered without `in_sop` while no packet is open is consumed and ignored. It causes no write and does not enter the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Channel enable; low clears all state |
| ring_base_qw | input | ADDR_W-3 | Ring base address in qword units |
| ring_len | input | ADDR_W | Ring length in bytes, multiple of 8 |
| rd_off | input | ADDR_W | Firmware read offset within the ring, bytes |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Byte beat accepted when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_zlp | input | 1 | Beat carries no byte (zero-length packet) |
| in_ep | input | EP_W | Endpoint number, sampled at start-of-packet |
| in_setup | input | 1 | Setup/control flag, sampled at start-of-packet |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the qword |
| mem_wr_data | output | 64 | Qword data |
| irq_pkt_done | output | 1 | Packet stored pulse |
| ovf_flag | output | 1 | Sticky packet-dropped flag |

## Verification
A wrong byte-lane counter or a stale accumulator corrupts the very next payload qword written. That shows up as a data mismatch within eight beats. A wrong data pointer or header slot shows up as a write outside the expected offset, or as a header found in the wrong slot at the packet's interrupt. A wrap error appears at the first packet to cross the ring end. A faulty free-space test shows up at the start of a packet, either as writes during a packet that should be dropped or as a missing interrupt for one that should be stored. Memory is pre-filled with a sentinel so that a skipped or duplicated write is caught.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    localparam int LANES = 8;
    localparam int LANE_W = 3;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DATA = 3'd1,
        S_DROP = 3'd2,
        S_HDR  = 3'd3,
        S_HDRW = 3'd4
    } st_e;
endpackage

// File: rtl/usbrx_ring_free.sv
module usbrx_ring_free #(
    parameter int ADDR_W = 32,
    parameter int NEED   = 80
) (
    input  logic [ADDR_W-1:0] wr_off,
    input  logic [ADDR_W-1:0] rd_off,
    input  logic [ADDR_W-1:0] ring_len,
    output logic              room_ok
);
    logic [ADDR_W-1:0] used;
    logic [ADDR_W-1:0] free_b;

    always_comb begin
        if (wr_off >= rd_off) used = wr_off - rd_off;
        else                  used = wr_off + ring_len - rd_off;
        free_b  = ring_len - used;
        room_ok = (free_b >= ADDR_W'(NEED));
    end
endmodule

// File: rtl/usbrx_lane_merge.sv
module usbrx_lane_merge
    import usbrx_pkg::*;
(
    input  logic [63:0]       acc_in,
    input  logic [LANE_W-1:0] lane_sel,
    input  logic [7:0]        byte_in,
    input  logic              take,
    output logic [63:0]       acc_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign acc_out[8*i +: 8] = (take && lane_sel == LANE_W'(i)) ? byte_in : acc_in[8*i +: 8];
    end
endmodule

// File: rtl/usbrx_qword_packer.sv
module usbrx_qword_packer
    import usbrx_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int EP_W    = 2,
    parameter int MAX_PKT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-4:0] ring_base_qw,
    input  logic [ADDR_W-1:0] ring_len,
    input  logic [ADDR_W-1:0] rd_off,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_zlp,
    input  logic [EP_W-1:0]   in_ep,
    input  logic              in_setup,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic              irq_pkt_done,
    output logic              ovf_flag
);
    localparam int CNT_W = $clog2(MAX_PKT + 1);
    localparam int NEED  = MAX_PKT + 2 * LANES;
    localparam int EP_LO = 8;
    localparam int SU_B  = EP_LO + EP_W;

    typedef struct packed {
        st_e               st;
        logic [63:0]       acc;
        logic [LANE_W-1:0] bcnt;
        logic [CNT_W-1:0]  pcnt;
        logic [ADDR_W-1:0] wr_off;
        logic [ADDR_W-1:0] dptr;
        logic [ADDR_W-1:0] hdr_off;
        logic [EP_W-1:0]   ep;
        logic              setup;
        logic              wv;
        logic [ADDR_W-1:0] waddr;
        logic [63:0]       wdata;
        logic              ovf;
        logic              irq;
    } regs_t;

    regs_t q, d;

    function automatic logic [ADDR_W-1:0] ring_adv(input logic [ADDR_W-1:0] off,
                                                   input logic [ADDR_W-1:0] len);
        logic [ADDR_W-1:0] nxt;
        nxt = off + ADDR_W'(LANES);
        return (nxt >= len) ? nxt - len : nxt;
    endfunction

    logic [ADDR_W-1:0] base_a;
    logic              room_ok;
    logic              in_ready_c;
    logic              fire;
    logic              take;
    logic              idle;
    logic [63:0]       cur_acc;
    logic [LANE_W-1:0] cur_b;
    logic [CNT_W-1:0]  cur_p;
    logic [ADDR_W-1:0] cur_dptr;
    logic [63:0]       m_acc;
    logic [LANE_W:0]   nb;
    logic [63:0]       hdr_word;

    assign base_a     = {ring_base_qw, 3'b000};
    assign idle       = (q.st == S_IDLE);
    assign in_ready_c = enable && ((q.st == S_DROP) ||
                                   ((q.st == S_IDLE || q.st == S_DATA) && !q.wv));
    assign fire       = in_valid && in_ready_c;
    assign cur_acc    = idle ? 64'd0 : q.acc;
    assign cur_b      = idle ? '0 : q.bcnt;
    assign cur_p      = idle ? '0 : q.pcnt;
    assign cur_dptr   = idle ? ring_adv(q.wr_off, ring_len) : q.dptr;
    assign take       = fire && !in_zlp && (cur_p < CNT_W'(MAX_PKT));
    assign nb         = {1'b0, cur_b} + {{LANE_W{1'b0}}, take};
    assign hdr_word   = 64'(q.pcnt) | (64'(q.ep) << EP_LO) | (64'(q.setup) << SU_B);

    usbrx_ring_free #(.ADDR_W(ADDR_W), .NEED(NEED)) u_free (
        .wr_off  (q.wr_off),
        .rd_off  (rd_off),
        .ring_len(ring_len),
        .room_ok (room_ok)
    );

    usbrx_lane_merge u_merge (
        .acc_in  (cur_acc),
        .lane_sel(cur_b),
        .byte_in (in_data),
        .take    (take),
        .acc_out (m_acc)
    );

    always_comb begin
        logic pack;
        pack  = 1'b0;
        d     = q;
        d.irq = 1'b0;
        if (q.wv && mem_wr_ready) d.wv = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (fire && in_sop) begin
                    if (room_ok) begin
                        d.hdr_off = q.wr_off;
                        d.ep      = in_ep;
                        d.setup   = in_setup;
                        d.st      = S_DATA;
                        pack      = 1'b1;
                    end else begin
                        d.ovf = 1'b1;
                        if (!in_eop) d.st = S_DROP;
                    end
                end
            end
            S_DATA: begin
                if (fire) pack = 1'b1;
            end
            S_DROP: begin
                if (fire && in_eop) d.st = S_IDLE;
            end
            S_HDR: begin
                if (!q.wv) begin
                    d.wv    = 1'b1;
                    d.waddr = base_a + q.hdr_off;
                    d.wdata = hdr_word;
                    d.st    = S_HDRW;
                end
            end
            S_HDRW: begin
                if (q.wv && mem_wr_ready) begin
                    d.irq    = 1'b1;
                    d.wr_off = q.dptr;
                    d.st     = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (pack) begin
            d.pcnt = cur_p + CNT_W'(take);
            if (nb == (LANE_W + 1)'(LANES) || (in_eop && nb != '0)) begin
                d.wv    = 1'b1;
                d.waddr = base_a + cur_dptr;
                d.wdata = m_acc;
                d.dptr  = ring_adv(cur_dptr, ring_len);
                d.acc   = 64'd0;
                d.bcnt  = '0;
            end else begin
                d.acc  = m_acc;
                d.bcnt = nb[LANE_W-1:0];
                d.dptr = cur_dptr;
            end
            if (in_eop) d.st = S_HDR;
        end

        if (!enable) begin
            d.st     = S_IDLE;
            d.wv     = 1'b0;
            d.irq    = 1'b0;
            d.ovf    = 1'b0;
            d.wr_off = '0;
            d.pcnt   = '0;
            d.bcnt   = '0;
            d.acc    = 64'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= S_IDLE;
            q.wv     <= 1'b0;
            q.irq    <= 1'b0;
            q.ovf    <= 1'b0;
            q.wr_off <= '0;
            q.pcnt   <= '0;
            q.bcnt   <= '0;
            q.acc    <= 64'd0;
            q.dptr   <= '0;
            q.hdr_off <= '0;
            q.ep     <= '0;
            q.setup  <= 1'b0;
            q.waddr  <= '0;
            q.wdata  <= 64'd0;
        end else begin
            q <= d;
        end
    end

    assign in_ready     = in_ready_c;
    assign mem_wr_valid = q.wv;
    assign mem_wr_addr  = q.waddr;
    assign mem_wr_data  = q.wdata;
    assign irq_pkt_done = q.irq;
    assign ovf_flag     = q.ovf;

    // R10: a pending write keeps its address and data until taken
    a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wv && !mem_wr_ready && enable) |=> (q.wv && $stable(q.waddr) && $stable(q.wdata)));

    // R1: disabling silences the write port and the interrupt
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!q.wv && !q.irq && !q.ovf));

    // R5: the packet-done interrupt lasts one cycle
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    // R5: the interrupt only follows a header write in flight
    a_r5_irq_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> ($past(q.st) == S_HDRW));

    // R7: a dropped packet issues no write
    a_r7_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DROP) |-> !q.wv);

    // R9: stored byte count never passes the packet limit
    a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= CNT_W'(MAX_PKT));
endmodule

// File: tb/sim_usbrx_qword_packer.sv
module sim_usbrx_qword_packer;
    localparam int LEN    = 256;
    localparam int NQW    = LEN / 8;
    localparam logic [31:0] BASE_A = 32'h0000_1000;
    localparam logic [63:0] SENT   = 64'hA5A5_5A5A_C3C3_3C3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [28:0] ring_base_qw = BASE_A[31:3];
    logic [31:0] ring_len = 32'(LEN);
    logic [31:0] rd_off = 32'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'd0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_zlp = 1'b0;
    logic [1:0]  in_ep = 2'd0;
    logic        in_setup = 1'b0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        irq_pkt_done;
    logic        ovf_flag;

    always #10 clk = ~clk;

    usbrx_qword_packer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ring_base_qw(ring_base_qw), .ring_len(ring_len), .rd_off(rd_off),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_zlp(in_zlp),
        .in_ep(in_ep), .in_setup(in_setup),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .irq_pkt_done(irq_pkt_done), .ovf_flag(ovf_flag)
    );

    int n_tests = 0;
    int n_fail = 0;
    int wcount = 0;
    int irq_cnt = 0;
    int hold_viol = 0;
    int out_range = 0;
    int wp = 0;
    logic [31:0] last_addr = 32'd0;
    logic [63:0] mem [0:NQW-1];
    logic [7:0]  pb [0:79];
    bit          rdy_rand = 1'b0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = 32'd0;
    logic [63:0] prev_data = 64'd0;
    bit          finished = 1'b0;

    // memory model, sampled away from the rising edge
    always @(negedge clk) begin
        if (prev_stall && (!mem_wr_valid || mem_wr_addr != prev_addr || mem_wr_data != prev_data) && enable)
            hold_viol++;
        mem_wr_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
        if (mem_wr_valid && mem_wr_ready) begin
            int idx;
            idx = int'((mem_wr_addr - BASE_A) >> 3);
            if (mem_wr_addr < BASE_A || idx >= NQW) out_range++;
            else mem[idx] = mem_wr_data;
            wcount++;
            last_addr = mem_wr_addr;
        end
        prev_stall = mem_wr_valid && !mem_wr_ready;
        prev_addr  = mem_wr_addr;
        prev_data  = mem_wr_data;
        if (irq_pkt_done) irq_cnt++;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic beat(input logic [7:0] b, input bit sop, input bit eop, input bit zlp,
                        input logic [1:0] ep, input bit su);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sop = sop; in_eop = eop; in_zlp = zlp;
        in_ep = ep; in_setup = su;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt(input int ep, input bit su, input int n);
        for (int i = 0; i < 80; i++) pb[i] = 8'($urandom);
        if (n == 0) beat(8'h00, 1'b1, 1'b1, 1'b1, 2'(ep), su);
        else for (int i = 0; i < n; i++) beat(pb[i], i == 0, i == n - 1, 1'b0, 2'(ep), su);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_zlp = 1'b0;
    endtask

    function automatic logic [63:0] exp_qw(input int k, input int stored);
        logic [63:0] v;
        v = 64'd0;
        for (int j = 0; j < 8; j++)
            if (8 * k + j < stored) v[8*j +: 8] = pb[8*k + j];
        return v;
    endfunction

    // expects the packet to be stored; keep_rd leaves rd_off as set by the caller
    task automatic run_pkt(input int ep, input bit su, input int n, input bit keep_rd);
        int stored, nq, hdr, w0, i0, off;
        logic [63:0] eh;
        if (!keep_rd) rd_off = 32'(wp);
        stored = (n > 64) ? 64 : n;
        nq = (stored + 7) / 8;
        hdr = wp;
        for (int k = 0; k <= nq; k++) mem[((hdr + 8 * k) % LEN) / 8] = SENT;
        w0 = wcount; i0 = irq_cnt;
        send_pkt(ep, su, n);
        for (int t = 0; t < 2000 && irq_cnt == i0; t++) @(negedge clk);
        chk("R5", "irq count", 64'(irq_cnt), 64'(i0 + 1));
        chk("R5", "write count", 64'(wcount - w0), 64'(nq + 1));
        chk("R5", "last write is header slot", 64'(last_addr), 64'(BASE_A + 32'(hdr)));
        eh = 64'(stored) | (64'(ep) << 8) | (64'(su) << 10);
        chk((n > 64) ? "R9" : (n == 0 ? "R8" : "R3"), "header word", mem[hdr / 8], eh);
        for (int k = 0; k < nq; k++) begin
            off = (hdr + 8 + 8 * k) % LEN;
            if (off < hdr)                          chk("R6", "wrapped payload", mem[off / 8], exp_qw(k, stored));
            else if (k == nq - 1 && stored % 8 != 0) chk("R4", "padded last qword", mem[off / 8], exp_qw(k, stored));
            else                                    chk("R2", "payload qword", mem[off / 8], exp_qw(k, stored));
        end
        wp = (hdr + 8 + 8 * nq) % LEN;
    endtask

    task automatic run_drop(input int n);
        int w0, i0;
        rd_off = 32'((wp + 72) % LEN);
        w0 = wcount; i0 = irq_cnt;
        send_pkt(1, 1'b0, n);
        repeat (20) @(negedge clk);
        chk("R7", "no writes for dropped packet", 64'(wcount - w0), 64'd0);
        chk("R7", "no irq for dropped packet", 64'(irq_cnt - i0), 64'd0);
        chk("R7", "overflow flag set", 64'(ovf_flag), 64'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            chk("R10", "write hold violations", 64'(hold_viol), 64'd0);
            chk("R2", "writes outside ring", 64'(out_range), 64'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NQW; i++) mem[i] = SENT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset and disabled state
        chk("R1", "in_ready while disabled", 64'(in_ready), 64'd0);
        chk("R1", "write valid while disabled", 64'(mem_wr_valid), 64'd0);
        chk("R1", "irq while disabled", 64'(irq_pkt_done), 64'd0);
        chk("R1", "ovf after reset", 64'(ovf_flag), 64'd0);
        enable = 1'b1;
        @(negedge clk);

        run_pkt(0, 1'b1, 8, 1'b0);
        run_pkt(2, 1'b0, 13, 1'b0);
        run_pkt(3, 1'b0, 0, 1'b0);
        run_pkt(1, 1'b0, 70, 1'b0);

        // R11: stray byte while idle
        begin
            int w0;
            w0 = wcount;
            beat(8'hEE, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0);
            @(negedge clk); in_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk("R11", "stray byte writes", 64'(wcount - w0), 64'd0);
            run_pkt(1, 1'b0, 5, 1'b0);
        end

        // R6: back-to-back full packets cross the ring end
        rdy_rand = 1'b1;
        for (int i = 0; i < 5; i++) run_pkt(i % 4, 1'b0, 64, 1'b0);

        // R7: overflow drop, then the exact boundary is accepted
        run_drop(20);
        run_drop(1);
        rd_off = 32'((wp + 80) % LEN);
        run_pkt(2, 1'b0, 64, 1'b1);
        chk("R7", "flag sticky after accepted packet", 64'(ovf_flag), 64'd1);
        @(negedge clk); enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "flag cleared by disable", 64'(ovf_flag), 64'd0);
        chk("R1", "in_ready low when disabled", 64'(in_ready), 64'd0);
        wp = 0;
        enable = 1'b1;
        @(negedge clk);

        // random mix
        for (int i = 0; i < 24; i++) begin
            int ep;
            ep = $urandom_range(0, 3);
            run_pkt(ep, (ep == 0) && ($urandom_range(0, 1) == 1), $urandom_range(0, 70), 1'b0);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule